// File: doc/BRIEF.md
# Framed Full-Duplex SPI Peripheral Engine

This block is the device side of an SPI target that talks in fixed frames of six words. While the host shifts in a command word, a checksum word and four zero words, the engine shifts out three kinds of word in the same bit times. First comes a response word, which is the command taken from the previous complete frame. Then come four channel samples taken from a parallel bus. Last is a CRC-16 word computed over everything sent before it in the frame. All words in a frame have one length, chosen at run time as 16, 24 or 32 bits.

SCLK, CS and DIN are brought into the system clock domain through synchronisers, and edges are detected there. A raised chip select resets the framing at any point. When chip select is tied low, frames follow each other back to back. A system-clock timeout can then force the framing back to the start of a frame. A command is committed only when its frame has completed. It is then offered on a valid/ready stream and also loaded as the response for the next frame.

The command stream has these back-pressure rules. `cmd_valid` stays high, with its data unchanged, until a cycle where `cmd_ready` is high. If another frame completes while an entry is still pending, the newer command replaces the older one. The engine never stalls the serial link to wait for the stream.

Top module: `spi_frame_engine`

## Requirements
- R1: `cfg_wlen` selects the word length: code 0 gives 16 bits, code 1 gives 24, code 2 gives 32, and code 3 is treated as 24. A frame is six words of that length, and both directions shift MSB first.
- R2: The idle level of SCLK is low. DOUT takes each new bit after an SCLK rising edge and holds it until the next rising edge. DIN is sampled on SCLK falling edges.
- R3: The first word sent in a frame is the command word of the last completed frame. It is left-justified, and only its top word-length bits are sent. After reset this word is all zeros.
- R4: Word k+1, for k from 0 to 3, carries channel k, which is bits [24k+23:24k] of `sample_bus`. The samples are captured at the first SCLK rising edge of the frame. Each 24-bit sample is left-justified: eight zero bits follow it at 32-bit length, and only its upper 16 bits are sent at 16-bit length.
- R5: The sixth word is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed bit-serially, MSB first, over every bit of words one to five of the frame. It is left-justified in the word and padded with zeros.
- R6: When a frame completes, `cmd_word` holds the first received word and `cmd_chk` holds the second. Both are left-justified in 32 bits, and `cmd_valid` goes high.
- R7: `cmd_valid` and the data with it stay unchanged until `cmd_ready` is high. A frame that completes while an entry is pending replaces that entry.
- R8: CS high resets the bit and word position. The command of a frame that was cut short is discarded: no `cmd_valid` is raised, and the next response word is left unchanged.
- R9: With CS held low, the next frame starts on the SCLK rising edge that follows the last bit of a frame.
- R10: With `cfg_timeout_en` high, the position returns to the start of a frame if TIMEOUT_CYC system clocks (default 32768) pass after the first rising edge of a frame without that frame completing. The partial command is discarded.
- R11: With `cfg_timeout_en` low, a frame may pause for any length of time and then complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| cfg_wlen | input | 2 | Word length code |
| cfg_timeout_en | input | 1 | Enables the frame timeout |
| sample_bus | input | 96 | Four 24-bit channel samples, channel 0 in the low bits |
| cmd_valid | output | 1 | A committed command is available |
| cmd_ready | input | 1 | The consumer takes the command |
| cmd_word | output | 32 | Command word, left-justified |
| cmd_chk | output | 32 | Command checksum word, left-justified |

## Verification
The bench runs frames at every word-length code and predicts each word independently. It recomputes the CRC bit by bit, so a CRC seeded or fed wrongly, or taken over the wrong span, shows up at once. Each response word is checked against the command of the previous frame, which catches a design that answers in the same frame or that adopts a command cut off by CS or by the timeout. The sample bus changes in the middle of a frame, which exposes a design that reads the bus live instead of capturing it at frame start. Long stalls with CS held low check two things: with the timeout enabled the framing realigns, and with it disabled the frame resumes where it stopped.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int MAXW = 32;
  localparam int CRCW = 16;
  localparam logic [CRCW-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRCW-1:0] CRC_SEED = 16'hFFFF;

  function automatic logic [5:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    wlen_bits = 6'd16;
      2'd2:    wlen_bits = 6'd32;
      default: wlen_bits = 6'd24;
    endcase
  endfunction

  function automatic logic [CRCW-1:0] crc_step(input logic [CRCW-1:0] c, input logic b);
    crc_step = {c[CRCW-2:0], 1'b0} ^ ((c[CRCW-1] ^ b) ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_hi,
  output logic din_s
);
  logic [STAGES-1:0] sclk_q, cs_q, din_q;
  logic sclk_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_q <= '0; cs_q <= '1; din_q <= '0;
        end else begin
          sclk_q <= sclk; cs_q <= cs_n; din_q <= din;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sclk_q <= '0; cs_q <= '1; din_q <= '0;
        end else begin
          sclk_q <= {sclk_q[STAGES-2:0], sclk};
          cs_q   <= {cs_q[STAGES-2:0], cs_n};
          din_q  <= {din_q[STAGES-2:0], din};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_q[STAGES-1];
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;
  assign cs_hi     = cs_q[STAGES-1];
  assign din_s     = din_q[STAGES-1];
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl #(
  parameter int WORDS   = 6,
  parameter int TIMEOUT_CYC = 32768,
  localparam int WIDXW  = $clog2(WORDS),
  localparam int TOW    = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             cs_hi,
  input  logic [1:0]       wlen,
  input  logic             to_en,
  output logic [5:0]       bit_idx,
  output logic [WIDXW-1:0] word_idx,
  output logic             word_done,
  output logic             frame_done
);
  import sfe_pkg::*;

  logic [5:0]     wbits;
  logic           active;
  logic [TOW-1:0] to_cnt;
  logic           to_fire;
  logic           last_bit;

  assign wbits      = wlen_bits(wlen);
  assign last_bit   = (bit_idx == wbits - 6'd1);
  assign to_fire    = to_en && active && (to_cnt == TOW'(TIMEOUT_CYC - 1));
  assign word_done  = fall && last_bit && !cs_hi && !to_fire;
  assign frame_done = word_done && (word_idx == WIDXW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0; word_idx <= '0; active <= 1'b0; to_cnt <= '0;
    end else if (cs_hi || to_fire) begin
      bit_idx <= '0; word_idx <= '0; active <= 1'b0; to_cnt <= '0;
    end else begin
      if (rise) active <= 1'b1;
      if (active && to_cnt != TOW'(TIMEOUT_CYC - 1)) to_cnt <= to_cnt + 1'b1;
      if (fall) begin
        if (last_bit) begin
          bit_idx <= '0;
          if (frame_done) begin
            word_idx <= '0;
            active   <= 1'b0;
            to_cnt   <= '0;
          end else begin
            word_idx <= word_idx + 1'b1;
          end
        end else begin
          bit_idx <= bit_idx + 6'd1;
        end
      end
    end
  end

  // R1
  bit_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx < wbits);
  // R1
  word_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_idx < WIDXW'(WORDS));
  // R8
  cs_resets_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (bit_idx == '0 && word_idx == '0));
  // R10
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_en && to_cnt == TOW'(TIMEOUT_CYC - 1)) |=> (bit_idx == '0 && word_idx == '0));
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
  parameter int NCH   = 4,
  parameter int SW    = 24,
  parameter int WORDS = NCH + 2,
  localparam int WIDXW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              cs_hi,
  input  logic [5:0]        bit_idx,
  input  logic [WIDXW-1:0]  word_idx,
  input  logic [31:0]       resp,
  input  logic [NCH*SW-1:0] samples,
  output logic              dout
);
  import sfe_pkg::*;

  logic [31:0]       sh;
  logic [NCH*SW-1:0] smp_q;
  logic [CRCW-1:0]   crc;
  logic [31:0]       load_word;
  logic              first_bit;
  logic              next_bit;
  logic [CRCW-1:0]   crc_base;

  assign first_bit = (word_idx == '0) && (bit_idx == '0);

  always_comb begin
    load_word = '0;
    if (word_idx == '0) begin
      load_word = resp;
    end else if (word_idx == WIDXW'(WORDS - 1)) begin
      load_word = {crc, {(32-CRCW){1'b0}}};
    end else begin
      load_word = {smp_q[(int'(word_idx) - 1) * SW +: SW], {(32-SW){1'b0}}};
    end
  end

  assign next_bit = (bit_idx == '0) ? load_word[31] : sh[30];
  assign crc_base = first_bit ? CRC_SEED : crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; smp_q <= '0; crc <= CRC_SEED;
    end else if (rise && !cs_hi) begin
      if (first_bit) smp_q <= samples;
      sh <= (bit_idx == '0) ? load_word : {sh[30:0], 1'b0};
      if (word_idx != WIDXW'(WORDS - 1)) crc <= crc_step(crc_base, next_bit);
    end
  end

  assign dout = cs_hi ? 1'b0 : sh[31];

  // R2
  dout_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !cs_hi) |=> (cs_hi || $stable(dout)));
  // R4
  samples_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && first_bit) |=> $stable(smp_q));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int NCH         = 4,
  parameter int SW          = 24,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 32768,
  localparam int WORDS = NCH + 2,
  localparam int WIDXW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_timeout_en,
  input  logic [NCH*SW-1:0] sample_bus,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_word,
  output logic [31:0]       cmd_chk
);
  import sfe_pkg::*;

  logic             rise, fall, cs_hi, din_s;
  logic [5:0]       bit_idx;
  logic [WIDXW-1:0] word_idx;
  logic             word_done, frame_done;
  logic [31:0]      rx, rx_next, rx_left;
  logic [31:0]      cmd_q, chk_q, resp_q;
  logic [5:0]       wbits;

  sfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(rise), .sclk_fall(fall), .cs_hi(cs_hi), .din_s(din_s)
  );

  sfe_ctrl #(.WORDS(WORDS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cs_hi(cs_hi),
    .wlen(cfg_wlen), .to_en(cfg_timeout_en), .bit_idx(bit_idx),
    .word_idx(word_idx), .word_done(word_done), .frame_done(frame_done)
  );

  sfe_tx #(.NCH(NCH), .SW(SW), .WORDS(WORDS)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise(rise), .cs_hi(cs_hi), .bit_idx(bit_idx),
    .word_idx(word_idx), .resp(resp_q), .samples(sample_bus), .dout(dout)
  );

  assign wbits   = wlen_bits(cfg_wlen);
  assign rx_next = {rx[30:0], din_s};
  assign rx_left = rx_next << (6'd32 - wbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx <= '0; cmd_q <= '0; chk_q <= '0; resp_q <= '0;
      cmd_valid <= 1'b0; cmd_word <= '0; cmd_chk <= '0;
    end else begin
      if (fall && !cs_hi) rx <= rx_next;
      if (word_done && word_idx == WIDXW'(0)) cmd_q <= rx_left;
      if (word_done && word_idx == WIDXW'(1)) chk_q <= rx_left;
      if (frame_done) begin
        resp_q    <= cmd_q;
        cmd_word  <= cmd_q;
        cmd_chk   <= chk_q;
        cmd_valid <= 1'b1;
      end else if (cmd_ready) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  // R3
  resp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(resp_q));
  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);
  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !frame_done) |=> ($stable(cmd_word) && $stable(cmd_chk)));
  // R6
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(frame_done));
endmodule

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int TO = 32768;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, din = 0;
  logic dout, cmd_valid, cmd_ready = 0, to_en = 0;
  logic [1:0] wlen = 0;
  logic [95:0] sample_bus = '0;
  logic [31:0] cmd_word, cmd_chk;

  int n_checks = 0, n_fail = 0;
  logic [31:0] tx_w [6];
  logic [31:0] rx_w [6];
  logic [31:0] exp_w [6];
  logic [23:0] smp [4];
  logic [31:0] prev_cmd = '0;
  int r2_bad = 0;
  logic last_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_engine i_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout),
    .cfg_wlen(wlen), .cfg_timeout_en(to_en), .sample_bus(sample_bus),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_chk(cmd_chk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wl(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd2) ? 32 : 24;
  endfunction

  function automatic logic [31:0] mask(input int w);
    return 32'((64'd1 << w) - 1);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive bits [first, first+n) of the frame stream, sampling DOUT before each falling edge.
  task automatic host_bits(input int w, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      int wi = i / w;
      int b  = w - 1 - (i % w);
      sclk = 1; din = tx_w[wi][b];
      cyc(HALF);
      last_dout = dout;
      rx_w[wi] = {rx_w[wi][30:0], dout};
      sclk = 0;
      cyc(HALF);
      if (dout !== last_dout) r2_bad++;
    end
  endtask

  task automatic setup(input int f, input int w);
    tx_w[0] = (32'(f) * 32'h9E3779B9 + 32'h5A17) & mask(w);
    tx_w[1] = (32'(f) * 32'h0101_0B0D + 32'hC3) & mask(w);
    for (int i = 2; i < 6; i++) tx_w[i] = '0;
    for (int k = 0; k < 4; k++) begin
      smp[k] = 24'(32'(f) * 32'h13579B + 32'(k) * 32'h2468AC + 32'h0F0F0F);
      sample_bus[k*24 +: 24] = smp[k];
    end
    for (int i = 0; i < 6; i++) rx_w[i] = '0;
  endtask

  task automatic expect_words(input int w);
    logic [15:0] crc = 16'hFFFF;
    exp_w[0] = prev_cmd >> (32 - w);
    for (int k = 0; k < 4; k++) exp_w[k+1] = {smp[k], 8'h00} >> (32 - w);
    for (int i = 0; i < 5; i++)
      for (int b = w - 1; b >= 0; b--) begin
        logic fb = crc[15] ^ exp_w[i][b];
        crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
      end
    exp_w[5] = {crc, 16'h0} >> (32 - w);
  endtask

  task automatic check_words(input int w, input string tag);
    check({"R3 response ", tag}, rx_w[0], exp_w[0]);
    for (int k = 1; k < 5; k++) check({"R4 sample word ", tag}, rx_w[k], exp_w[k]);
    check({"R5 crc word ", tag}, rx_w[5], exp_w[5]);
  endtask

  task automatic check_cmd(input int w, input string tag);
    check({"R6 cmd valid ", tag}, 32'(cmd_valid), 32'd1);
    check({"R6 cmd word ", tag}, cmd_word, tx_w[0] << (32 - w));
    check({"R6 cmd chk ", tag}, cmd_chk, tx_w[1] << (32 - w));
    prev_cmd = tx_w[0] << (32 - w);
    cmd_ready = 1; cyc(1); cmd_ready = 0; cyc(1);
    check({"R7 valid drops after ready ", tag}, 32'(cmd_valid), 32'd0);
  endtask

  // Full frame bracketed by CS.
  task automatic full_frame(input int f, input logic [1:0] code, input bit swap_mid);
    int w = wl(code);
    wlen = code;
    setup(f, w);
    expect_words(w);
    cs_n = 0; cyc(4);
    if (swap_mid) begin
      host_bits(w, 0, w);
      sample_bus = ~sample_bus;   // R4: must not affect this frame
      host_bits(w, w, 5 * w);
    end else begin
      host_bits(w, 0, 6 * w);
    end
    cyc(4); cs_n = 1; cyc(4);
    check_words(w, "full");
    check_cmd(w, "full");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    check("R8 reset dout", 32'(dout), 32'd0);
    check("R6 reset cmd_valid", 32'(cmd_valid), 32'd0);

    // R1 R3 R4 R5 R6: sweep every length code, response of frame 1 is zero (R3)
    for (int f = 1; f <= 8; f++) full_frame(f, 2'(f % 4), f == 3);
    check("R2 dout held across low phase", 32'(r2_bad), 32'd0);

    // R8: frame cut short by CS
    wlen = 2'd1; setup(20, 24);
    cs_n = 0; cyc(4); host_bits(24, 0, 30); cs_n = 1; cyc(6);
    check("R8 no cmd from cut frame", 32'(cmd_valid), 32'd0);
    full_frame(21, 2'd1, 0);

    // R7: back-pressure, newer command replaces pending one
    begin
      wlen = 2'd0; setup(30, 16); expect_words(16);
      cs_n = 0; cyc(4); host_bits(16, 0, 96); cyc(4); cs_n = 1; cyc(20);
      check("R7 valid held without ready", 32'(cmd_valid), 32'd1);
      check("R7 data held", cmd_word, tx_w[0] << 16);
      prev_cmd = tx_w[0] << 16;
      setup(31, 16); expect_words(16);
      cs_n = 0; cyc(4); host_bits(16, 0, 96); cyc(4); cs_n = 1; cyc(4);
      check_words(16, "bp");
      check("R7 newer replaces pending", cmd_word, tx_w[0] << 16);
      check_cmd(16, "bp");
    end

    // R9: back-to-back frames with CS held low
    to_en = 1; wlen = 2'd2; cs_n = 0; cyc(4);
    for (int f = 40; f < 42; f++) begin
      setup(f, 32); expect_words(32);
      host_bits(32, 0, 192); cyc(4);
      check_words(32, "R9 cs low");
      check_cmd(32, "R9 cs low");
    end

    // R10: stall with timeout enabled realigns framing
    setup(50, 32); host_bits(32, 0, 10);
    cyc(TO + 200);
    check("R10 stalled cmd discarded", 32'(cmd_valid), 32'd0);
    setup(51, 32); expect_words(32);
    host_bits(32, 0, 192); cyc(4);
    check_words(32, "R10 after timeout");
    check_cmd(32, "R10 after timeout");

    // R11: stall with timeout disabled resumes
    to_en = 0; wlen = 2'd1;
    setup(60, 24); expect_words(24);
    host_bits(24, 0, 10);
    cyc(TO + 200);
    host_bits(24, 10, 134); cyc(4);
    check_words(24, "R11 paused");
    check_cmd(24, "R11 paused");
    cs_n = 1; cyc(4);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule